// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block carries out one multi-register load or store. It is given the control fields of the instruction, the current base register value, the instruction's own address and the current privilege level. It then walks the 16-bit register list from the lowest listed register to the highest. For each one it issues a single 32-bit memory request over a valid/ready port. The register file is served through one combinational read port, which supplies store data, and one write port, which takes load data.

Decrementing forms do not run the addresses backwards. The start address is moved down by four bytes per listed register, and the transfer then climbs upward like an incrementing one. When the request stream ends, the block raises a one-cycle finish pulse. That pulse carries the base writeback value, a pipeline flush request when the program counter was loaded, and a request to copy the saved status into the current status. While the transfer targets the user register bank, the block also drives a user-bank select. A privileged-only form issued from an unprivileged mode is refused with an error.

Top module: `blkxfer_seq`

## Requirements
- R1: `xfer_ctl` holds the fields: bit 24 pre (address step before the access), bit 23 up (increment), bit 22 S, bit 21 writeback, bit 20 load (0 = store), bits 19:16 base register, bits 15:0 register list. A `start` pulse is taken only when the block is idle. The first request is valid in the cycle after `start`. Out of reset, no request, write, user-bank or finish output is active.
- R2: Exactly one request is issued per listed register, in ascending register order, and each address is 4 above the previous one. A store of an ordinary register sends the read-port data for that register. A load writes `mem_rdata` to the register being transferred, in the handshake cycle.
- R3: With up=1 and a non-empty list, the first address is base+4 when pre=1 and base when pre=0. The writeback value is base + 4×count.
- R4: With up=0 and a non-empty list, the first address is base − 4×count when pre=1 and base − 4×count + 4 when pre=0. The writeback value is base − 4×count.
- R5: `wb_en` is raised only together with `done`, and only when the writeback bit is set. It is suppressed for a load whose list contains the base register.
- R6: A store that lists the base register sends the original base when the base is the lowest listed register, and sends the writeback value otherwise.
- R7: A store of register 15 sends the instruction address + 12.
- R8: An empty list makes exactly one access, at the base address, in either direction. A load writes register 15 with the data whose low two bits are cleared. A store sends the instruction address + 12. The writeback value is base + 0x40.
- R9: When S=1 and the transfer is a load that lists register 15, `psr_restore` is raised with `done`. Any other use of S=1 holds `user_bank` high for every request of the transfer.
- R10: When S=1 and `mode_unpriv`=1, the block issues no request. It raises `done` and `err` one cycle after `start`, with `wb_en`, `flush` and `psr_restore` low.
- R11: The first request of a transfer has `mem_seq`=0, and every later request has `mem_seq`=1.
- R12: `flush` is raised with `done` exactly when the transfer loaded register 15.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the address, write enable and write data stay unchanged.
- R14: `done` is high for exactly the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| xfer_ctl | input | 25 | Instruction control fields, bits 24:0 |
| base_in | input | 32 | Current base register value |
| insn_addr | input | 32 | Address of the instruction |
| mode_unpriv | input | 1 | Core is in an unprivileged mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Word address of the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 32 | Store data |
| mem_seq | output | 1 | Sequential-access marker |
| mem_rdata | input | 32 | Load data, valid in the handshake cycle |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| user_bank | output | 1 | Transfer targets the user register bank |
| done | output | 1 | Transfer finished (one cycle) |
| err | output | 1 | Refused privileged form |
| flush | output | 1 | Pipeline flush request |
| psr_restore | output | 1 | Copy saved status into current status |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index |
| wb_val | output | 32 | Base writeback value |

## Verification
The first request is due one cycle after `start`, and load data reaches the register-file write port in the handshake cycle itself. The finish pulse follows the last handshake by exactly one cycle; a refused form finishes one cycle after `start`. The bench samples every output on the falling edge and records a cycle count beside each handshake, register write and finish pulse. Each of these timing relations is then checked as a difference between recorded cycle counts, so ready stalls cannot shift an expected value onto the wrong cycle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int unsigned BXS_DW   = 32;
  localparam int unsigned BXS_NREG = 16;
  localparam int unsigned BXS_IDXW = $clog2(BXS_NREG);
  localparam int unsigned BXS_CNTW = BXS_IDXW + 1;
  localparam int unsigned BXS_CTLW = 5 + BXS_IDXW + BXS_NREG;

  localparam logic [BXS_DW-1:0] BXS_STEP       = BXS_DW'(4);
  localparam logic [BXS_DW-1:0] BXS_EMPTY_SPAN = BXS_DW'(64);
  localparam logic [BXS_DW-1:0] BXS_PC_AHEAD   = BXS_DW'(12);

  typedef enum logic [1:0] {BXS_IDLE, BXS_RUN, BXS_FIN} bxs_state_e;

  typedef struct packed {
    logic                pre;
    logic                up;
    logic                sbit;
    logic                wb;
    logic                load;
    logic [BXS_IDXW-1:0] rn;
    logic [BXS_NREG-1:0] list;
  } bxs_op_t;

  function automatic logic [BXS_CNTW-1:0] bxs_popcount(input logic [BXS_NREG-1:0] l);
    logic [BXS_CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < BXS_NREG; i++) n = n + BXS_CNTW'(l[i]);
    return n;
  endfunction

  function automatic logic [BXS_DW-1:0] bxs_span(input logic [BXS_CNTW-1:0] n);
    return {{(BXS_DW-BXS_CNTW){1'b0}}, n} << 2;
  endfunction

  function automatic logic [BXS_DW-1:0] bxs_first_addr(
      input logic [BXS_DW-1:0] base, input logic [BXS_CNTW-1:0] n,
      input logic up, input logic pre, input logic empty);
    logic [BXS_DW-1:0] low;
    low = base - bxs_span(n);
    if (empty) return base;
    if (up) return pre ? base + BXS_STEP : base;
    return pre ? low : low + BXS_STEP;
  endfunction

  function automatic logic [BXS_DW-1:0] bxs_wb_value(
      input logic [BXS_DW-1:0] base, input logic [BXS_CNTW-1:0] n,
      input logic up, input logic empty);
    if (empty) return base + BXS_EMPTY_SPAN;
    return up ? base + bxs_span(n) : base - bxs_span(n);
  endfunction
endpackage

// File: rtl/bxs_decode.sv
module bxs_decode
  import bxs_pkg::*;
#(
  parameter int unsigned DW   = BXS_DW,
  parameter int unsigned NREG = BXS_NREG,
  parameter int unsigned IW   = BXS_IDXW,
  parameter int unsigned CW   = BXS_CNTW,
  parameter int unsigned CTLW = BXS_CTLW
) (
  input  logic [CTLW-1:0] ctl,
  input  logic [DW-1:0]   base,
  input  logic            unpriv,
  output logic            is_load,
  output logic [IW-1:0]   rn,
  output logic [NREG-1:0] list,
  output logic [CW-1:0]   count,
  output logic            empty,
  output logic [DW-1:0]   first_addr,
  output logic [DW-1:0]   wb_value,
  output logic            wb_allowed,
  output logic            bank_sel,
  output logic            restore,
  output logic            illegal
);
  bxs_op_t op;

  always_comb begin
    op         = bxs_op_t'(ctl);
    is_load    = op.load;
    rn         = op.rn;
    list       = op.list;
    count      = bxs_popcount(op.list);
    empty      = (op.list == '0);
    first_addr = bxs_first_addr(base, count, op.up, op.pre, empty);
    wb_value   = bxs_wb_value(base, count, op.up, empty);
    wb_allowed = op.wb & ~(op.load & op.list[op.rn]);
    restore    = op.sbit & op.load & op.list[NREG-1];
    bank_sel   = op.sbit & ~restore;
    illegal    = op.sbit & unpriv;
  end
endmodule

// File: rtl/bxs_pick.sv
module bxs_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = mask[g] & ~seen[g];
    assign seen[g+1] = seen[g] | mask[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bxs_wdata.sv
module bxs_wdata
  import bxs_pkg::*;
#(
  parameter int unsigned DW   = BXS_DW,
  parameter int unsigned NREG = BXS_NREG,
  parameter int unsigned IW   = BXS_IDXW
) (
  input  logic [IW-1:0] cur_idx,
  input  logic [IW-1:0] rn,
  input  logic          first,
  input  logic          empty,
  input  logic [DW-1:0] rf_data,
  input  logic [DW-1:0] orig_base,
  input  logic [DW-1:0] wb_value,
  input  logic [DW-1:0] insn_addr,
  output logic [DW-1:0] wdata
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  always_comb begin
    if (empty)                wdata = insn_addr + BXS_PC_AHEAD;
    else if (cur_idx == rn)   wdata = first ? orig_base : wb_value;
    else if (cur_idx == PC_IDX) wdata = insn_addr + BXS_PC_AHEAD;
    else                      wdata = rf_data;
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import bxs_pkg::*;
#(
  parameter int unsigned DW   = BXS_DW,
  parameter int unsigned NREG = BXS_NREG,
  parameter int unsigned IW   = BXS_IDXW,
  parameter int unsigned CW   = BXS_CNTW,
  parameter int unsigned CTLW = BXS_CTLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CTLW-1:0] xfer_ctl,
  input  logic [DW-1:0]   base_in,
  input  logic [DW-1:0]   insn_addr,
  input  logic            mode_unpriv,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [DW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_seq,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_wr_en,
  output logic [IW-1:0]   rf_wr_idx,
  output logic [DW-1:0]   rf_wr_data,
  output logic            user_bank,
  output logic            done,
  output logic            err,
  output logic            flush,
  output logic            psr_restore,
  output logic            wb_en,
  output logic [IW-1:0]   wb_idx,
  output logic [DW-1:0]   wb_val
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  // decoded view of the incoming request
  logic            d_load, d_empty, d_wbok, d_bank, d_rest, d_illegal;
  logic [IW-1:0]   d_rn;
  logic [NREG-1:0] d_list;
  logic [CW-1:0]   d_count;
  logic [DW-1:0]   d_first, d_wbv;

  bxs_decode #(.DW(DW), .NREG(NREG), .IW(IW), .CW(CW), .CTLW(CTLW)) u_dec (
    .ctl(xfer_ctl), .base(base_in), .unpriv(mode_unpriv),
    .is_load(d_load), .rn(d_rn), .list(d_list), .count(d_count),
    .empty(d_empty), .first_addr(d_first), .wb_value(d_wbv),
    .wb_allowed(d_wbok), .bank_sel(d_bank), .restore(d_rest),
    .illegal(d_illegal)
  );

  // transfer state
  bxs_state_e      st_q;
  logic            load_q, empty_q, wbok_q, bank_q, rest_q, flush_q, err_q;
  logic [IW-1:0]   rn_q;
  logic [NREG-1:0] pend_q;
  logic [CW-1:0]   cnt_q, tot_q;
  logic [DW-1:0]   base_q, ia_q, addr_q, wbv_q;

  // named internal events
  logic          accept, hs, xfer_first, xfer_last;
  logic [IW-1:0] pick_idx, cur_idx;

  bxs_pick #(.N(NREG), .IW(IW)) u_pick (.mask(pend_q), .idx(pick_idx));

  assign accept     = (st_q == BXS_IDLE) && start;
  assign hs         = (st_q == BXS_RUN) && mem_req_ready;
  assign xfer_first = (cnt_q == '0);
  assign xfer_last  = hs && ((cnt_q + CW'(1)) == tot_q);
  assign cur_idx    = empty_q ? PC_IDX : pick_idx;

  bxs_wdata #(.DW(DW), .NREG(NREG), .IW(IW)) u_wd (
    .cur_idx(cur_idx), .rn(rn_q), .first(xfer_first), .empty(empty_q),
    .rf_data(rf_rd_data), .orig_base(base_q), .wb_value(wbv_q),
    .insn_addr(ia_q), .wdata(mem_wdata)
  );

  assign mem_req_valid = (st_q == BXS_RUN);
  assign mem_addr      = addr_q;
  assign mem_we        = mem_req_valid & ~load_q;
  assign mem_seq       = ~xfer_first;
  assign rf_rd_idx     = cur_idx;
  assign rf_wr_en      = hs & load_q;
  assign rf_wr_idx     = cur_idx;
  assign rf_wr_data    = empty_q ? (mem_rdata & ~DW'(3)) : mem_rdata;
  assign user_bank     = mem_req_valid & bank_q;
  assign done          = (st_q == BXS_FIN);
  assign err           = done & err_q;
  assign flush         = done & flush_q;
  assign psr_restore   = done & rest_q;
  assign wb_en         = done & wbok_q;
  assign wb_idx        = rn_q;
  assign wb_val        = wbv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BXS_IDLE;
      load_q  <= 1'b0;
      empty_q <= 1'b0;
      wbok_q  <= 1'b0;
      bank_q  <= 1'b0;
      rest_q  <= 1'b0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
      rn_q    <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
      tot_q   <= '0;
      base_q  <= '0;
      ia_q    <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
    end else begin
      case (st_q)
        BXS_IDLE: begin
          if (accept) begin
            load_q  <= d_load;
            empty_q <= d_empty;
            wbok_q  <= d_wbok & ~d_illegal;
            bank_q  <= d_bank;
            rest_q  <= d_rest & ~d_illegal;
            flush_q <= 1'b0;
            err_q   <= d_illegal;
            rn_q    <= d_rn;
            pend_q  <= d_list;
            cnt_q   <= '0;
            tot_q   <= d_empty ? CW'(1) : d_count;
            base_q  <= base_in;
            ia_q    <= insn_addr;
            addr_q  <= d_first;
            wbv_q   <= d_wbv;
            st_q    <= d_illegal ? BXS_FIN : BXS_RUN;
          end
        end
        BXS_RUN: begin
          if (hs) begin
            pend_q[cur_idx] <= 1'b0;
            addr_q          <= addr_q + BXS_STEP;
            cnt_q           <= cnt_q + CW'(1);
            if (load_q && (cur_idx == PC_IDX)) flush_q <= 1'b1;
            if (xfer_last) st_q <= BXS_FIN;
          end
        end
        default: st_q <= BXS_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !xfer_last |=> mem_req_valid && (mem_addr == $past(mem_addr) + BXS_STEP)); // R2
  AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> done && !mem_req_valid); // R14
  AST_SEQ_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !xfer_last |=> mem_seq); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done); // R5
  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wb_en && !flush && !psr_restore); // R10
  AST_REFUSE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_illegal |=> done && err && !mem_req_valid); // R10
  AST_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !d_illegal |=> mem_req_valid && !mem_seq); // R1
endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IA    = 32'h0000_0200;
  localparam logic [31:0] RDKEY = 32'h5A5A_0000;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] base;
    logic        stall;
    logic [4:0]  n;
    logic [31:0] first;
    logic        wben;
    logic [31:0] wbv;
    logic        flush;
    logic        rest;
    logic        ub;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'hE8B1_00F0, 32'h1000, 1'b0, 5'd4,  32'h1000, 1'b1, 32'h1010, 1'b0, 1'b0, 1'b0},
    '{32'hE92D_4006, 32'h2000, 1'b1, 5'd3,  32'h1FF4, 1'b1, 32'h1FF4, 1'b0, 1'b0, 1'b0},
    '{32'hE982_000C, 32'h3000, 1'b0, 5'd2,  32'h3004, 1'b0, 32'h3008, 1'b0, 1'b0, 1'b0},
    '{32'hE823_000A, 32'h4000, 1'b1, 5'd2,  32'h3FFC, 1'b1, 32'h3FF8, 1'b0, 1'b0, 1'b0},
    '{32'hE8B5_0060, 32'h5000, 1'b0, 5'd2,  32'h5000, 1'b0, 32'h5008, 1'b0, 1'b0, 1'b0},
    '{32'hE894_8001, 32'h6000, 1'b1, 5'd2,  32'h6000, 1'b0, 32'h6008, 1'b1, 1'b0, 1'b0},
    '{32'hE8B6_0000, 32'h7000, 1'b0, 5'd1,  32'h7000, 1'b1, 32'h7040, 1'b1, 1'b0, 1'b0},
    '{32'hE926_0000, 32'h7100, 1'b1, 5'd1,  32'h7100, 1'b1, 32'h7140, 1'b0, 1'b0, 1'b0},
    '{32'hE8C7_8010, 32'h8000, 1'b0, 5'd2,  32'h8000, 1'b0, 32'h8008, 1'b0, 1'b0, 1'b1},
    '{32'hE8D8_8002, 32'h9000, 1'b0, 5'd2,  32'h9000, 1'b0, 32'h9008, 1'b1, 1'b1, 1'b0},
    '{32'hE8D9_0003, 32'hA000, 1'b1, 5'd2,  32'hA000, 1'b0, 32'hA008, 1'b0, 1'b0, 1'b1},
    '{32'hE820_FFFF, 32'hB000, 1'b0, 5'd16, 32'hAFC4, 1'b1, 32'hAFC0, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_unpriv = 1'b0, stall_en = 1'b0;
  logic [24:0] xfer_ctl = '0;
  logic [31:0] base_in = '0;
  logic        mem_req_valid, mem_req_ready, mem_we, mem_seq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, wb_val;
  logic [3:0]  rf_rd_idx, rf_wr_idx, wb_idx;
  logic        rf_wr_en, user_bank, done, err, flush, psr_restore, wb_en;

  int cyc = 0, total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_req_ready = !stall_en || cyc[0];
  assign mem_rdata     = mem_addr ^ RDKEY;
  assign rf_rd_data    = 32'h1000_0000 | 32'(rf_rd_idx);

  blkxfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_ctl(xfer_ctl),
    .base_in(base_in), .insn_addr(IA), .mode_unpriv(mode_unpriv),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_seq(mem_seq), .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .user_bank(user_bank), .done(done), .err(err),
    .flush(flush), .psr_restore(psr_restore), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val)
  );

  // event logs, filled on the falling edge
  logic [31:0] h_addr [256];
  logic [31:0] h_wd   [256];
  logic        h_we   [256];
  logic        h_seq  [256];
  logic        h_ub   [256];
  int          h_cyc  [256];
  logic [3:0]  w_idx  [256];
  logic [31:0] w_dat  [256];
  int hc = 0, wc = 0, dcnt = 0, d_cyc = 0, hold_bad = 0;
  logic d_wb = 0, d_fl = 0, d_ps = 0, d_err = 0;
  logic [31:0] d_wbv = '0;
  logic hold_arm = 0;
  logic [31:0] hold_addr = '0, hold_wd = '0;

  always @(negedge clk) begin
    if (hold_arm && mem_req_valid && (mem_addr != hold_addr || mem_wdata != hold_wd)) hold_bad++;
    hold_arm  = mem_req_valid && !mem_req_ready;
    hold_addr = mem_addr;
    hold_wd   = mem_wdata;
    if (mem_req_valid && mem_req_ready && hc < 256) begin
      h_addr[hc] = mem_addr; h_wd[hc] = mem_wdata; h_we[hc] = mem_we;
      h_seq[hc] = mem_seq; h_ub[hc] = user_bank; h_cyc[hc] = cyc; hc++;
    end
    if (rf_wr_en && wc < 256) begin
      w_idx[wc] = rf_wr_idx; w_dat[wc] = rf_wr_data; wc++;
    end
    if (done) begin
      dcnt++; d_cyc = cyc; d_wb = wb_en; d_wbv = wb_val;
      d_fl = flush; d_ps = psr_restore; d_err = err;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  int h0, w0, d0, s_cyc;

  task automatic run_op(input logic [31:0] w, input logic [31:0] base, input logic unpriv, input logic st);
    @(negedge clk);
    h0 = hc; w0 = wc; d0 = dcnt; s_cyc = cyc;
    xfer_ctl = w[24:0]; base_in = base; mode_unpriv = unpriv; stall_en = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 400 && dcnt == d0; k++) @(posedge clk);
    @(negedge clk);
    chk(dcnt == d0 + 1, "R14 finish pulse seen once", 32'(dcnt - d0), 32'd1);
    stall_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'(cyc), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !done && !rf_wr_en && !user_bank, "R1 reset outputs idle",
        {28'b0, mem_req_valid, done, rf_wr_en, user_bank}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_valid && !done, "R1 idle after reset", {30'b0, mem_req_valid, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VECS[v];
      automatic logic [15:0] lst = t.word[15:0];
      automatic logic [3:0] rn = t.word[19:16];
      automatic logic ld = t.word[20];
      automatic logic up = t.word[23];
      automatic int k = 0;
      run_op(t.word, t.base, 1'b0, t.stall);
      chk(hc - h0 == int'(t.n), "R2 access count", 32'(hc - h0), 32'(t.n));
      chk(h_addr[h0] == t.first, lst == 0 ? "R8 first address" : (up ? "R3 first address" : "R4 first address"),
          h_addr[h0], t.first);
      if (!t.stall) chk(h_cyc[h0] == s_cyc + 1, "R1 first request one cycle after start",
                        32'(h_cyc[h0] - s_cyc), 32'd1);
      if (lst == 0) begin
        chk(h_we[h0] == !ld, "R8 direction", 32'(h_we[h0]), 32'(!ld));
        if (ld) chk(wc - w0 == 1 && w_idx[w0] == 4'd15 && w_dat[w0] == ((t.base ^ RDKEY) & ~32'd3),
                    "R8 load into register 15", w_dat[w0], (t.base ^ RDKEY) & ~32'd3);
        else    chk(h_wd[h0] == IA + 12, "R8 store of pc", h_wd[h0], IA + 12);
      end else begin
        for (int r = 0; r < 16; r++) begin
          if (lst[r]) begin
            automatic logic [31:0] ea = t.first + 32'(4 * k);
            chk(h_addr[h0+k] == ea, "R2 ascending address", h_addr[h0+k], ea);
            chk(h_seq[h0+k] == (k != 0), "R11 sequential marker", 32'(h_seq[h0+k]), 32'(k != 0));
            chk(h_ub[h0+k] == t.ub, "R9 user bank select", 32'(h_ub[h0+k]), 32'(t.ub));
            if (ld) begin
              chk(w_idx[w0+k] == 4'(r) && w_dat[w0+k] == (ea ^ RDKEY), "R2 load write",
                  {w_idx[w0+k], w_dat[w0+k][27:0]}, {4'(r), (ea ^ RDKEY)} [31:0]);
            end else if (4'(r) == rn) begin
              automatic logic [31:0] e = (k == 0) ? t.base : t.wbv;
              chk(h_wd[h0+k] == e, "R6 stored base", h_wd[h0+k], e);
            end else if (r == 15) begin
              chk(h_wd[h0+k] == IA + 12, "R7 stored pc", h_wd[h0+k], IA + 12);
            end else begin
              chk(h_wd[h0+k] == (32'h1000_0000 | 32'(r)), "R2 store data", h_wd[h0+k], 32'h1000_0000 | 32'(r));
            end
            k++;
          end
        end
      end
      chk(d_cyc == h_cyc[hc-1] + 1, "R14 done after last handshake", 32'(d_cyc - h_cyc[hc-1]), 32'd1);
      chk(d_wb == t.wben, "R5 writeback enable", 32'(d_wb), 32'(t.wben));
      if (t.wben) chk(d_wbv == t.wbv, lst == 0 ? "R8 writeback value" : (up ? "R3 writeback value" : "R4 writeback value"),
                      d_wbv, t.wbv);
      chk(d_fl == t.flush, "R12 flush", 32'(d_fl), 32'(t.flush));
      chk(d_ps == t.rest, "R9 status restore", 32'(d_ps), 32'(t.rest));
      chk(!d_err, "R10 no error when privileged", 32'(d_err), 32'd0);
    end

    // refused privileged form from an unprivileged mode
    run_op(32'hE8C7_8010, 32'h8000, 1'b1, 1'b0);
    chk(hc == h0, "R10 no request issued", 32'(hc - h0), 32'd0);
    chk(d_err && !d_wb && !d_fl && !d_ps, "R10 error only", {28'b0, d_err, d_wb, d_fl, d_ps}, 32'h8);
    chk(d_cyc == s_cyc + 1, "R10 done one cycle after start", 32'(d_cyc - s_cyc), 32'd1);

    chk(hold_bad == 0, "R13 request held during stall", 32'(hold_bad), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule